// File: doc/BRIEF.md
# Block Remap Controller with In-Block Pointers

This controller sits between request logic and a nonvolatile memory that is organised as 64-byte blocks. A block that has worn out is not dropped. It is reused to hold a forwarding pointer to a healthy replacement block. Every block carries a single flag bit that marks it as either data or pointer. When an access reaches a block marked as pointer, the controller reads the forwarding address and repeats the access at that address. The pointer always names the final location, so an access is redirected at most once.

The pointer sits in cells that may themselves be faulty. For this reason it is written as several identical copies across the block and recovered by a bitwise majority vote. A small fully associative cache keeps recent original-to-final mappings, and on a hit the access goes straight to the final block. A retire request is used when a replacement block wears out in turn. It takes a fresh block from a free-block counter and overwrites the pointer in the original block, so no chain of pointers ever builds up. The memory array and its error detection are not part of this block.

The controller handles one request at a time. Its states are S_IDLE (waiting for a request), S_ORIG (accessing the original block), S_FINAL (accessing the final block), S_RET_RD (reading the original block during a retire) and S_RET_WR (writing the new pointer).

The transitions are:
- S_IDLE goes to S_RET_RD on a retire request.
- S_IDLE goes to S_FINAL on a read or write that hits in the cache.
- S_IDLE goes to S_ORIG on a read or write that misses.
- S_ORIG goes to S_FINAL when the block is flagged as pointer.
- S_ORIG goes back to S_IDLE when the block is flagged as data.
- S_FINAL goes to S_IDLE when the access completes.
- S_RET_RD goes to S_RET_WR when the read completes.
- S_RET_WR goes to S_IDLE when the write completes.

Top module: `remap_ctrl`

## Requirements
- R1: After reset the controller is idle. In that state req_ready is 1, mem_req is 0 and rsp_valid is 0, and no memory access is issued while req_ready is 1.
- R2: Request codes on req_op are 00 read, 01 write and 10 retire. Memory codes on mem_op are 00 data read, 01 data write and 10 pointer write. A read or write to a block whose mem_rflag returns 0 takes exactly one memory access. That access goes to the requested address, with code 00 for a read or 01 for a write. The response then gives rsp_addr equal to the requested address and rsp_redir equal to 0. rsp_valid lasts one cycle.
- R3: Suppose a read or write misses in the cache and the original block returns mem_rflag equal to 1. The controller then makes a second access at the final address, using the request's own code. The response gives rsp_addr equal to the final address and rsp_redir equal to 1, after two accesses in total.
- R4: mem_rdata holds NCOPY copies of a PW-bit pointer, with copy k at bits [k*PW +: PW]. Each pointer bit is 1 when more than half of the copies hold 1. The final address is the low AW bits of the voted pointer. A single corrupted copy out of four has no effect.
- R5: After a redirection has been learned, a later read or write to the same original address hits in the cache. It takes one access, made directly at the final address.
- R6: The cache holds CACHE_N mappings and fills new entries in round-robin order. Once CACHE_N+1 distinct originals have been filled, the oldest entry is gone and takes two accesses again. Entries that have not been replaced still hit.
- R7: A retire takes two accesses: a data read (00) of the original block, then a pointer write (10) to the original block. Every copy in mem_wdata holds the fresh address. Fresh addresses start at FREE_BASE and increase by one with each retire. The response gives the fresh address with rsp_redir equal to 1.
- R8: After a retire, the original address maps to the fresh block. On a hit it takes one access, and on a miss it takes two accesses with the pointer read back from memory. The former final block is never written by a retire, so a direct access to it passes through unredirected.
- R9: While mem_req is high and mem_ack has not arrived, mem_req, mem_addr and mem_op hold their values.
- R10: A request is accepted only while req_ready is 1. req_ready stays 0 from the cycle after acceptance until the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_op | input | 2 | Request code: 00 read, 01 write, 10 retire |
| req_addr | input | AW | Original block address |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_addr | output | AW | Block actually accessed, or the fresh block for a retire |
| rsp_redir | output | 1 | 1 if the access was redirected or was a retire |
| mem_req | output | 1 | Memory access request, held until mem_ack |
| mem_op | output | 2 | Memory code: 00 data read, 01 data write, 10 pointer write |
| mem_addr | output | AW | Memory block address |
| mem_wdata | output | NCOPY*PW | Replicated pointer for a pointer write |
| mem_ack | input | 1 | Access complete; mem_rflag and mem_rdata are valid |
| mem_rflag | input | 1 | Flag of the accessed block: 1 means it holds a pointer |
| mem_rdata | input | NCOPY*PW | Pointer copies read from the block |

## Verification
The bench builds the controller with AW=8, PW=64, NCOPY=4, CACHE_N=4 and FREE_BASE=0xC0. The 8-bit address space lets a small behavioural memory with corruptible pointer copies cover every block. A four-entry cache fills up after four remapped originals, which brings round-robin eviction within reach. It also makes a later retire push out an entry that was updated earlier, so the pointer written by the retire has to be read back from memory and voted. The fresh-address window at 0xC0 stays clear of the preloaded blocks, so the old targets can be reached directly to show they are untouched.

// File: rtl/remap_pkg.sv
package remap_pkg;

    typedef enum logic [1:0] {
        OP_READ   = 2'b00,
        OP_WRITE  = 2'b01,
        OP_RETIRE = 2'b10
    } req_op_e;

    typedef enum logic [1:0] {
        MEM_DRD = 2'b00,
        MEM_DWR = 2'b01,
        MEM_PWR = 2'b10
    } mem_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ORIG,
        S_FINAL,
        S_RET_RD,
        S_RET_WR
    } state_e;

endpackage

// File: rtl/ptr_vote.sv
module ptr_vote #(
    parameter int PW    = 64,
    parameter int NCOPY = 4
) (
    input  logic [NCOPY*PW-1:0] copies,
    output logic [PW-1:0]       voted
);
    localparam int CW = $clog2(NCOPY + 1);

    for (genvar b = 0; b < PW; b++) begin : g_bit
        logic [CW-1:0] ones;
        always_comb begin
            ones = '0;
            for (int k = 0; k < NCOPY; k++) begin
                ones = ones + CW'(copies[k*PW + b]);
            end
        end
        assign voted[b] = (ones > CW'(NCOPY / 2));
    end

endmodule

// File: rtl/remap_cache.sv
module remap_cache #(
    parameter int AW      = 26,
    parameter int ENTRIES = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] lk_addr,
    output logic          lk_hit,
    output logic [AW-1:0] lk_final,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_orig,
    input  logic [AW-1:0] wr_final
);
    localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] vld_q;
    logic [AW-1:0]      tag_q [ENTRIES];
    logic [AW-1:0]      fin_q [ENTRIES];
    logic [IW-1:0]      vic_q;
    logic [ENTRIES-1:0] lk_match;
    logic [ENTRIES-1:0] wr_match;
    logic [IW-1:0]      wr_idx;
    logic               wr_hit;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        assign lk_match[g] = vld_q[g] && (tag_q[g] == lk_addr);
        assign wr_match[g] = vld_q[g] && (tag_q[g] == wr_orig);
    end

    assign lk_hit = |lk_match;

    always_comb begin
        lk_final = '0;
        wr_idx   = vic_q;
        wr_hit   = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_match[i]) lk_final = fin_q[i];
            if (wr_match[i]) begin
                wr_idx = IW'(i);
                wr_hit = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            vic_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_idx] <= 1'b1;
            tag_q[wr_idx] <= wr_orig;
            fin_q[wr_idx] <= wr_final;
            if (!wr_hit) begin
                vic_q <= (vic_q == IW'(ENTRIES - 1)) ? '0 : vic_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/remap_ctrl.sv
module remap_ctrl
    import remap_pkg::*;
#(
    parameter int AW        = 26,
    parameter int PW        = 64,
    parameter int NCOPY     = 4,
    parameter int CACHE_N   = 16,
    parameter int FREE_BASE = 1024
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [1:0]          req_op,
    input  logic [AW-1:0]       req_addr,
    output logic                rsp_valid,
    output logic [AW-1:0]       rsp_addr,
    output logic                rsp_redir,
    output logic                mem_req,
    output logic [1:0]          mem_op,
    output logic [AW-1:0]       mem_addr,
    output logic [NCOPY*PW-1:0] mem_wdata,
    input  logic                mem_ack,
    input  logic                mem_rflag,
    input  logic [NCOPY*PW-1:0] mem_rdata
);
    localparam int DW = NCOPY * PW;

    state_e        state_q, state_d;
    req_op_e       op_q;
    logic [AW-1:0] addr_q, final_q, free_q;
    logic          rsp_valid_q, rsp_redir_q;
    logic [AW-1:0] rsp_addr_q;

    logic          accept, load_final, bump_free, cache_wr;
    logic          rsp_set, rsp_redir_d;
    logic [AW-1:0] rsp_addr_d;
    mem_op_e       mem_op_c, data_op;
    logic          lk_hit;
    logic [AW-1:0] lk_final;
    logic [PW-1:0] voted;
    logic [AW-1:0] vote_addr;
    logic [AW-1:0] cache_fin;
    logic [PW-1:0] fresh_ptr;

    ptr_vote #(.PW(PW), .NCOPY(NCOPY)) vote_i (
        .copies (mem_rdata),
        .voted  (voted)
    );

    assign vote_addr = voted[AW-1:0];
    assign fresh_ptr = PW'(free_q);

    remap_cache #(.AW(AW), .ENTRIES(CACHE_N)) cache_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_addr  (req_addr),
        .lk_hit   (lk_hit),
        .lk_final (lk_final),
        .wr_en    (cache_wr),
        .wr_orig  (addr_q),
        .wr_final (cache_fin)
    );

    assign data_op = (op_q == OP_WRITE) ? MEM_DWR : MEM_DRD;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d     = state_q;
        req_ready   = 1'b0;
        mem_req     = 1'b0;
        mem_op_c    = MEM_DRD;
        mem_addr    = addr_q;
        accept      = 1'b0;
        load_final  = 1'b0;
        bump_free   = 1'b0;
        cache_wr    = 1'b0;
        cache_fin   = vote_addr;
        rsp_set     = 1'b0;
        rsp_addr_d  = addr_q;
        rsp_redir_d = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    accept = 1'b1;
                    if (req_op == OP_RETIRE) state_d = S_RET_RD;
                    else if (lk_hit)         state_d = S_FINAL;
                    else                     state_d = S_ORIG;
                end
            end
            S_ORIG: begin
                mem_req  = 1'b1;
                mem_op_c = data_op;
                if (mem_ack) begin
                    if (mem_rflag) begin
                        load_final = 1'b1;
                        cache_wr   = 1'b1;
                        state_d    = S_FINAL;
                    end else begin
                        rsp_set = 1'b1;
                        state_d = S_IDLE;
                    end
                end
            end
            S_FINAL: begin
                mem_req  = 1'b1;
                mem_op_c = data_op;
                mem_addr = final_q;
                if (mem_ack) begin
                    rsp_set     = 1'b1;
                    rsp_addr_d  = final_q;
                    rsp_redir_d = 1'b1;
                    state_d     = S_IDLE;
                end
            end
            S_RET_RD: begin
                mem_req = 1'b1;
                if (mem_ack) state_d = S_RET_WR;
            end
            S_RET_WR: begin
                mem_req  = 1'b1;
                mem_op_c = MEM_PWR;
                if (mem_ack) begin
                    cache_wr    = 1'b1;
                    cache_fin   = free_q;
                    bump_free   = 1'b1;
                    rsp_set     = 1'b1;
                    rsp_addr_d  = free_q;
                    rsp_redir_d = 1'b1;
                    state_d     = S_IDLE;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q        <= OP_READ;
            addr_q      <= '0;
            final_q     <= '0;
            free_q      <= AW'(FREE_BASE);
            rsp_valid_q <= 1'b0;
            rsp_addr_q  <= '0;
            rsp_redir_q <= 1'b0;
        end else begin
            rsp_valid_q <= rsp_set;
            if (rsp_set) begin
                rsp_addr_q  <= rsp_addr_d;
                rsp_redir_q <= rsp_redir_d;
            end
            if (accept) begin
                op_q    <= req_op_e'(req_op);
                addr_q  <= req_addr;
                final_q <= lk_final;
            end
            if (load_final) final_q <= vote_addr;
            if (bump_free)  free_q  <= free_q + 1'b1;
        end
    end

    assign mem_op    = mem_op_c;
    assign mem_wdata = {NCOPY{fresh_ptr}};
    assign rsp_valid = rsp_valid_q;
    assign rsp_addr  = rsp_addr_q;
    assign rsp_redir = rsp_redir_q;

    logic unused_ok;
    assign unused_ok = ^{voted[PW-1:AW], DW[0]};

endmodule

// File: rtl/remap_ctrl_chk.sv
module remap_ctrl_chk #(
    parameter int AW    = 26,
    parameter int PW    = 64,
    parameter int NCOPY = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_ready,
    input logic [1:0]          req_op,
    input logic                rsp_valid,
    input logic                mem_req,
    input logic [1:0]          mem_op,
    input logic [AW-1:0]       mem_addr,
    input logic [NCOPY*PW-1:0] mem_wdata,
    input logic                mem_ack
);
    function automatic logic copies_equal(input logic [NCOPY*PW-1:0] w);
        logic eq;
        eq = 1'b1;
        for (int k = 1; k < NCOPY; k++) begin
            if (w[k*PW +: PW] != w[0 +: PW]) eq = 1'b0;
        end
        return eq;
    endfunction

    logic in_retire;
    always_ff @(posedge clk) begin
        if (!rst_n) in_retire <= 1'b0;
        else if (req_valid && req_ready) in_retire <= (req_op == 2'b10);
        else if (rsp_valid) in_retire <= 1'b0;
    end

    assert_no_mem_when_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req);

    assert_rsp_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_ptr_copies_equal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_op == 2'b10) |-> copies_equal(mem_wdata));

    assert_ptr_write_in_retire_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_op == 2'b10) |-> in_retire);

    assert_mem_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_op)));

    assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

endmodule

bind remap_ctrl remap_ctrl_chk #(.AW(AW), .PW(PW), .NCOPY(NCOPY)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_op    (req_op),
    .rsp_valid (rsp_valid),
    .mem_req   (mem_req),
    .mem_op    (mem_op),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack)
);

// File: tb/remap_ctrl_tb_top.sv
module remap_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int PW = 64;
    localparam int NCOPY = 4;
    localparam int DW = NCOPY * PW;
    localparam int CACHE_N = 4;
    localparam int FREE_BASE = 'hC0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [1:0] req_op = 2'b00;
    logic [AW-1:0] req_addr = '0;
    logic rsp_valid, rsp_redir;
    logic [AW-1:0] rsp_addr;
    logic mem_req;
    logic [1:0] mem_op;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic mem_ack;
    logic mem_rflag;
    logic [DW-1:0] mem_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    remap_ctrl #(.AW(AW), .PW(PW), .NCOPY(NCOPY), .CACHE_N(CACHE_N),
                 .FREE_BASE(FREE_BASE)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_redir(rsp_redir),
        .mem_req(mem_req), .mem_op(mem_op), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rflag(mem_rflag), .mem_rdata(mem_rdata)
    );

    // behavioural memory, one-cycle acknowledge
    logic          pl_en = 1'b0;
    logic [AW-1:0] pl_addr = '0;
    logic [DW-1:0] pl_data = '0;
    logic          flag_m [1<<AW];
    logic [DW-1:0] ptr_m  [1<<AW];

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_rflag <= 1'b0;
            mem_rdata <= '0;
            for (int i = 0; i < (1<<AW); i++) begin
                flag_m[i] <= 1'b0;
                ptr_m[i]  <= '0;
            end
        end else begin
            mem_ack <= 1'b0;
            if (pl_en) begin
                flag_m[pl_addr] <= 1'b1;
                ptr_m[pl_addr]  <= pl_data;
            end
            if (mem_req && !mem_ack) begin
                mem_ack   <= 1'b1;
                mem_rflag <= flag_m[mem_addr];
                mem_rdata <= ptr_m[mem_addr];
                if (mem_op == 2'b10) begin
                    flag_m[mem_addr] <= 1'b1;
                    ptr_m[mem_addr]  <= mem_wdata;
                end
            end
        end
    end

    typedef struct {
        logic [AW-1:0] addr;
        logic          redir;
        int            nacc;
        logic [1:0]    last_op;
        logic [AW-1:0] last_addr;
        string         tag;
    } exp_t;

    exp_t sb[$];
    int n_cmp = 0;
    int n_bad = 0;
    int acc_cnt = 0;
    logic [1:0] seen_op = 2'b00;
    logic [AW-1:0] seen_addr = '0;
    bit done = 0;

    // monitor
    always @(negedge clk) begin
        if (rst_n && mem_ack) begin
            acc_cnt++;
            seen_op   = mem_op;
            seen_addr = mem_addr;
        end
        if (rst_n && rsp_valid) begin
            if (sb.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R2 unexpected response addr=%0h", rsp_addr);
            end else begin
                exp_t e;
                e = sb.pop_front();
                n_cmp++;
                if (rsp_addr !== e.addr || rsp_redir !== e.redir || acc_cnt != e.nacc ||
                    seen_op !== e.last_op || seen_addr !== e.last_addr) begin
                    n_bad++;
                    $display("FAIL %s actual addr=%0h redir=%0d acc=%0d op=%0d maddr=%0h expected addr=%0h redir=%0d acc=%0d op=%0d maddr=%0h",
                             e.tag, rsp_addr, rsp_redir, acc_cnt, seen_op, seen_addr,
                             e.addr, e.redir, e.nacc, e.last_op, e.last_addr);
                end
            end
            acc_cnt = 0;
        end
    end

    task automatic check_bit(input logic act, input logic exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] mk_ptr(input logic [AW-1:0] tgt, input int bad_copy);
        logic [DW-1:0] w;
        for (int k = 0; k < NCOPY; k++) begin
            if (k == bad_copy) w[k*PW +: PW] = 64'hA5A5_5A5A_F0F0_0F0F ^ PW'(tgt);
            else               w[k*PW +: PW] = {{(PW-AW){1'b1}}, tgt};
        end
        return w;
    endfunction

    task automatic preload(input logic [AW-1:0] a, input logic [AW-1:0] tgt, input int bad_copy);
        @(negedge clk);
        pl_en = 1'b1; pl_addr = a; pl_data = mk_ptr(tgt, bad_copy);
        @(negedge clk);
        pl_en = 1'b0;
    endtask

    task automatic do_req(input logic [1:0] op, input logic [AW-1:0] a,
                          input logic [AW-1:0] exp_addr, input logic exp_redir,
                          input int exp_n, input logic [1:0] exp_op,
                          input logic [AW-1:0] exp_maddr, input string tag);
        exp_t e;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        e.addr = exp_addr; e.redir = exp_redir; e.nacc = exp_n;
        e.last_op = exp_op; e.last_addr = exp_maddr; e.tag = tag;
        sb.push_back(e);
        req_op = op; req_addr = a; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check_bit(req_ready, 1'b0, "R10 ready low while busy");
        while (sb.size() != 0) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_bit(req_ready, 1'b1, "R1 reset req_ready");
        check_bit(mem_req, 1'b0, "R1 reset mem_req");
        check_bit(rsp_valid, 1'b0, "R1 reset rsp_valid");

        preload(8'h10, 8'h50, -1);
        preload(8'h11, 8'h51, 2);
        preload(8'h12, 8'h52, 0);
        preload(8'h13, 8'h53, -1);
        preload(8'h14, 8'h54, 3);

        do_req(2'b00, 8'h05, 8'h05, 0, 1, 2'b00, 8'h05, "R2 read unflagged");
        do_req(2'b01, 8'h06, 8'h06, 0, 1, 2'b01, 8'h06, "R2 write unflagged");
        do_req(2'b00, 8'h10, 8'h50, 1, 2, 2'b00, 8'h50, "R3 read miss flagged");
        do_req(2'b00, 8'h10, 8'h50, 1, 1, 2'b00, 8'h50, "R5 read hit");
        do_req(2'b01, 8'h10, 8'h50, 1, 1, 2'b01, 8'h50, "R5 write hit");
        do_req(2'b00, 8'h11, 8'h51, 1, 2, 2'b00, 8'h51, "R4 vote copy2 bad");
        do_req(2'b01, 8'h12, 8'h52, 1, 2, 2'b01, 8'h52, "R3 R4 write miss copy0 bad");
        do_req(2'b00, 8'h13, 8'h53, 1, 2, 2'b00, 8'h53, "R3 fill last entry");
        do_req(2'b00, 8'h14, 8'h54, 1, 2, 2'b00, 8'h54, "R6 R4 fill evicts oldest");
        do_req(2'b00, 8'h11, 8'h51, 1, 1, 2'b00, 8'h51, "R6 kept entry hits");
        do_req(2'b00, 8'h10, 8'h50, 1, 2, 2'b00, 8'h50, "R6 evicted entry misses");
        do_req(2'b10, 8'h12, 8'hC0, 1, 2, 2'b10, 8'h12, "R7 retire first fresh");
        do_req(2'b00, 8'h12, 8'hC0, 1, 1, 2'b00, 8'hC0, "R8 cached fresh mapping");
        do_req(2'b00, 8'h52, 8'h52, 0, 1, 2'b00, 8'h52, "R8 old target untouched");
        do_req(2'b10, 8'h12, 8'hC1, 1, 2, 2'b10, 8'h12, "R7 retire counter step");
        do_req(2'b10, 8'h20, 8'hC2, 1, 2, 2'b10, 8'h20, "R7 retire unremapped block");
        do_req(2'b00, 8'h20, 8'hC2, 1, 1, 2'b00, 8'hC2, "R8 retired block hits");
        do_req(2'b00, 8'h12, 8'hC1, 1, 2, 2'b00, 8'hC1, "R8 R7 pointer read back from memory");
        do_req(2'b00, 8'hC1, 8'hC1, 0, 1, 2'b00, 8'hC1, "R8 fresh block is data");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired with %0d items pending", sb.size());
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule